// File: doc/BRIEF.md
# Counter Gate Source Selector

This block forms the gate signal for each of three counter channels. Every channel picks its gate from one of four sources: a level held in a software register, the output of the preceding counter in a ring of channels, the channel's own external gate pin, or a pulse-width capture path. An invert bit per channel can flip the chosen gate. The counting cores are not part of the block. Their OUT and CLK lines come in as inputs, pass through two-flop synchronizers, and are used for cascading and for status readback.

The pulse-width path is a small state machine per channel, fed by the synchronized gate pin. It has three states. ARMED waits for a rising edge. On that edge the gate opens at once and the machine moves ARMED→PASSING. PASSING keeps the gate open while the input stays high, and moves PASSING→DONE when the input falls. DONE holds the gate closed and has no exit of its own. A 0→1 change of the channel's re-arm bit forces any state→ARMED on the next clock, and global reset also enters ARMED. One positive pulse is therefore measured, and software must re-arm before the next pulse arrives. The machine runs in every mode. Its gate is used only when code 11 is selected.

Software reaches the block through a register port. Writes take effect at a clock edge. Reads are combinational from the read address.

Top module: `gate_source_select`

## Requirements
- R1: After global reset, every writable register reads 0, `gate_out` is all low, and every pulse-width machine is ARMED, so the first rising pulse passes.
- R2: Source code 00 drives the gate from bit n of the level register (address 2). A write is visible on `gate_out` right after the clock edge that takes it.
- R3: Source code 01 drives the gate of channel n from the synchronized OUT of channel n-1. Channel 0 takes channel 2's OUT.
- R4: Source code 10 drives the gate from the channel's external gate pin through a two-flop synchronizer. A pin change shows on `gate_out` after the second rising clock edge.
- R5: Bit n of the invert register (address 1) inverts channel n's gate for every source, including pulse-width mode.
- R6: Source code 11 passes exactly one positive pulse of the synchronized gate pin, with the same two-edge latency as R4. After that pulse ends, the gate stays low whatever the pin does.
- R7: Only a 0→1 change of bit n of the re-arm register (address 3) returns channel n's machine to ARMED, one clock after the write edge. Rewriting a 1 over a 1, or writing 0, has no effect. An input that is already high when the machine is armed does not open the gate; only a new rising edge does.
- R8: Address 4 is read-only status: bits [2:0] hold `gate_out`, bits [5:3] the synchronized OUT lines, bits [8:6] the synchronized CLK lines, and the other bits read 0. Writes to address 4 change nothing.
- R9: Address 0 holds the source codes, with channel n at bits [2n+1:2n]. Addresses 1 to 3 hold bits [2:0]. Unimplemented bits read 0, and addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| ext_gate_in | input | 3 | External gate pins, one per channel |
| cnt_out_in | input | 3 | OUT lines of the counting cores |
| cnt_clk_in | input | 3 | CLK lines of the counting cores |
| gate_out | output | 3 | Gate per channel |

## Verification
The due cycle depends on where the stimulus enters. Register writes reach `gate_out` and `rd_data` right after the write edge. Pin and OUT changes reach them after the second rising edge. A re-arm takes effect one edge after its write edge. The bench drives every input just after a falling edge and samples on later falling edges. Its latency checks sample one falling edge before the due edge, expecting the old value, and one falling edge after it, expecting the new value. The table-driven checks settle for three edges before they compare.

// File: rtl/gss_pkg.sv
package gss_pkg;
    localparam int REG_ADDR_W = 3;
    localparam int SYNC_DEPTH = 2;

    localparam logic [REG_ADDR_W-1:0] ADR_SELECT  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_INVERT  = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_SWLEVEL = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_REARM   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADR_STATUS  = 3'd4;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'b00,
        SRC_CHAIN = 2'b01,
        SRC_PIN   = 2'b10,
        SRC_PULSE = 2'b11
    } gate_src_e;

    typedef enum logic [1:0] {
        PW_ARMED   = 2'd0,
        PW_PASSING = 2'd1,
        PW_DONE    = 2'd2
    } pw_state_e;
endpackage

// File: rtl/gss_sync.sv
module gss_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = gss_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gss_pulse_fsm.sv
module gss_pulse_fsm
    import gss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic meas_s,
    input  logic rearm,
    output logic pass_gate
);
    pw_state_e state_q, state_d;
    logic      meas_prev_q;
    logic      meas_rise;

    assign meas_rise = meas_s & ~meas_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= PW_ARMED;
            meas_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            meas_prev_q <= meas_s;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (rearm) begin
            state_d = PW_ARMED;
        end else begin
            unique case (state_q)
                PW_ARMED:   if (meas_rise) state_d = PW_PASSING;
                PW_PASSING: if (!meas_s)   state_d = PW_DONE;
                PW_DONE:    state_d = PW_DONE;
                default:    state_d = PW_ARMED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PW_ARMED:   pass_gate = meas_rise;
            PW_PASSING: pass_gate = meas_s;
            PW_DONE:    pass_gate = 1'b0;
            default:    pass_gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/gss_regs.sv
module gss_regs
    import gss_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [REG_ADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]      status_word,
    output logic [DATA_W-1:0]      rd_data,
    output logic [2*NUM_CH-1:0]    cfg_sel,
    output logic [NUM_CH-1:0]      cfg_pol,
    output logic [NUM_CH-1:0]      cfg_lvl,
    output logic [NUM_CH-1:0]      cfg_rearm
);
    localparam int SEL_W = 2 * NUM_CH;

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:SEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sel   <= '0;
            cfg_pol   <= '0;
            cfg_lvl   <= '0;
            cfg_rearm <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_SELECT:  cfg_sel   <= wr_data[SEL_W-1:0];
                ADR_INVERT:  cfg_pol   <= wr_data[NUM_CH-1:0];
                ADR_SWLEVEL: cfg_lvl   <= wr_data[NUM_CH-1:0];
                ADR_REARM:   cfg_rearm <= wr_data[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_SELECT:  rd_data[SEL_W-1:0]  = cfg_sel;
            ADR_INVERT:  rd_data[NUM_CH-1:0] = cfg_pol;
            ADR_SWLEVEL: rd_data[NUM_CH-1:0] = cfg_lvl;
            ADR_REARM:   rd_data[NUM_CH-1:0] = cfg_rearm;
            ADR_STATUS:  rd_data             = status_word;
            default:     rd_data             = '0;
        endcase
    end
endmodule

// File: rtl/gate_source_select.sv
module gate_source_select
    import gss_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_CH-1:0]     ext_gate_in,
    input  logic [NUM_CH-1:0]     cnt_out_in,
    input  logic [NUM_CH-1:0]     cnt_clk_in,
    output logic [NUM_CH-1:0]     gate_out
);
    localparam int SYNC_W   = 3 * NUM_CH;
    localparam int STAT_USE = 3 * NUM_CH;

    logic [2*NUM_CH-1:0] cfg_sel;
    logic [NUM_CH-1:0]   cfg_pol;
    logic [NUM_CH-1:0]   cfg_lvl;
    logic [NUM_CH-1:0]   cfg_rearm;
    logic [NUM_CH-1:0]   rearm_prev_q;
    logic [NUM_CH-1:0]   rearm_edge;
    logic [NUM_CH-1:0]   ext_s, out_s, clk_s;
    logic [SYNC_W-1:0]   sync_q;
    logic [DATA_W-1:0]   status_word;

    gss_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cnt_clk_in, cnt_out_in, ext_gate_in}),
        .q     (sync_q)
    );

    assign ext_s = sync_q[NUM_CH-1:0];
    assign out_s = sync_q[2*NUM_CH-1:NUM_CH];
    assign clk_s = sync_q[3*NUM_CH-1:2*NUM_CH];

    gss_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .status_word (status_word),
        .rd_data     (rd_data),
        .cfg_sel     (cfg_sel),
        .cfg_pol     (cfg_pol),
        .cfg_lvl     (cfg_lvl),
        .cfg_rearm   (cfg_rearm)
    );

    // re-arm edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rearm_prev_q <= '0;
        else        rearm_prev_q <= cfg_rearm;
    end
    assign rearm_edge = cfg_rearm & ~rearm_prev_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int PREV = (n == 0) ? NUM_CH - 1 : n - 1;
        logic      pw_gate;
        logic      raw_gate;
        gate_src_e src;

        gss_pulse_fsm u_pw (
            .clk       (clk),
            .rst_n     (rst_n),
            .meas_s    (ext_s[n]),
            .rearm     (rearm_edge[n]),
            .pass_gate (pw_gate)
        );

        assign src = gate_src_e'(cfg_sel[2*n +: 2]);

        always_comb begin
            raw_gate = 1'b0;
            unique case (src)
                SRC_SOFT:  raw_gate = cfg_lvl[n];
                SRC_CHAIN: raw_gate = out_s[PREV];
                SRC_PIN:   raw_gate = ext_s[n];
                SRC_PULSE: raw_gate = pw_gate;
            endcase
        end

        assign gate_out[n] = raw_gate ^ cfg_pol[n];
    end

    assign status_word = DATA_W'({clk_s, out_s, gate_out});

    logic unused_stat;
    assign unused_stat = (STAT_USE > DATA_W);
endmodule

// File: rtl/gss_checker.sv
module gss_checker
    import gss_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0]     rd_data,
    input logic [NUM_CH-1:0]     ext_gate_in,
    input logic [NUM_CH-1:0]     cnt_out_in,
    input logic [NUM_CH-1:0]     gate_out,
    input logic [2*NUM_CH-1:0]   cfg_sel,
    input logic [NUM_CH-1:0]     cfg_pol,
    input logic [NUM_CH-1:0]     cfg_rearm
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_STATUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADR_STATUS) |-> (rd_data[NUM_CH-1:0] == gate_out)); // R8

    AST_STATUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && rd_addr == ADR_STATUS)
            |-> (rd_data[2*NUM_CH-1:NUM_CH] == $past(cnt_out_in, 2))); // R8

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        localparam int PREV = (n == 0) ? NUM_CH - 1 : n - 1;
        logic pulse_pos;
        assign pulse_pos = (cfg_sel[2*n +: 2] == 2'b11) && !cfg_pol[n];

        AST_SOFT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q != 2'd0 && cfg_sel[2*n +: 2] == 2'b00 && !$past(wr_en))
                |-> $stable(gate_out[n])); // R2

        AST_CHAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && cfg_sel[2*n +: 2] == 2'b01 && !cfg_pol[n])
                |-> (gate_out[n] == $past(cnt_out_in[PREV], 2))); // R3

        AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && cfg_sel[2*n +: 2] == 2'b10 && !cfg_pol[n])
                |-> (gate_out[n] == $past(ext_gate_in[n], 2))); // R4

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && pulse_pos && $past(pulse_pos) && $fell(gate_out[n]))
                |=> (!pulse_pos || !gate_out[n]
                     || ($past(cfg_rearm[n]) && !$past(cfg_rearm[n], 2))
                     || ($past(cfg_rearm[n], 2) && !$past(cfg_rearm[n], 3)))); // R6
    end
endmodule

bind gate_source_select gss_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .ext_gate_in (ext_gate_in),
    .cnt_out_in  (cnt_out_in),
    .gate_out    (gate_out),
    .cfg_sel     (cfg_sel),
    .cfg_pol     (cfg_pol),
    .cfg_rearm   (cfg_rearm)
);

// File: tb/gate_source_select_test.sv
module gate_source_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  ext_gate_in = '0;
    logic [2:0]  cnt_out_in = '0;
    logic [2:0]  cnt_clk_in = '0;
    logic [2:0]  gate_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gate_source_select uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_gate_in(ext_gate_in), .cnt_out_in(cnt_out_in),
        .cnt_clk_in(cnt_clk_in), .gate_out(gate_out)
    );

    // {sel[5:0], invert[2:0], level[2:0], pins[2:0], outs[2:0], expected gate[2:0]}
    localparam logic [20:0] VEC [7] = '{
        {6'b000000, 3'b000, 3'b101, 3'b000, 3'b000, 3'b101},
        {6'b000000, 3'b011, 3'b101, 3'b000, 3'b000, 3'b110},
        {6'b101010, 3'b000, 3'b000, 3'b110, 3'b000, 3'b110},
        {6'b010101, 3'b000, 3'b000, 3'b000, 3'b001, 3'b010},
        {6'b010101, 3'b000, 3'b000, 3'b000, 3'b100, 3'b001},
        {6'b000110, 3'b100, 3'b000, 3'b001, 3'b001, 3'b111},
        {6'b000110, 3'b111, 3'b000, 3'b001, 3'b000, 3'b110}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_read(input string req, input logic [2:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check("R1 gate after reset", {13'd0, gate_out}, 16'h0000);
        for (int a = 0; a < 8; a++) check_read("R1 register after reset", 3'(a), 16'h0000);

        // R9: readback and field widths
        write_reg(3'd0, 16'hFFFF);
        check_read("R9 select width", 3'd0, 16'h003F);
        write_reg(3'd0, 16'h0012);
        check_read("R9 select value", 3'd0, 16'h0012);
        write_reg(3'd1, 16'hFFFF);
        check_read("R9 invert width", 3'd1, 16'h0007);
        write_reg(3'd1, 16'h0000);
        write_reg(3'd5, 16'hFFFF);
        check_read("R9 unmapped address", 3'd5, 16'h0000);
        // R8: status writes ignored
        write_reg(3'd4, 16'hFFFF);
        check_read("R8 select kept after status write", 3'd0, 16'h0012);
        check("R8 gate after status write", {13'd0, gate_out}, 16'h0000);
        check_read("R8 status after write", 3'd4, 16'h0000);

        // R2/R3/R4/R5 table of source and invert settings
        for (int v = 0; v < 7; v++) begin
            ext_gate_in = VEC[v][8:6];
            cnt_out_in  = VEC[v][5:3];
            cnt_clk_in  = ~VEC[v][5:3];
            write_reg(3'd0, {10'd0, VEC[v][20:15]});
            write_reg(3'd1, {13'd0, VEC[v][14:12]});
            write_reg(3'd2, {13'd0, VEC[v][11:9]});
            check($sformatf("R2/R3/R4/R5 vector %0d gate", v), {13'd0, gate_out}, {13'd0, VEC[v][2:0]});
            check_read($sformatf("R8 vector %0d status", v), 3'd4,
                       {7'd0, ~VEC[v][5:3], VEC[v][5:3], VEC[v][2:0]});
        end

        // R4: two-edge latency of the pin path
        ext_gate_in = '0; cnt_out_in = '0; cnt_clk_in = '0;
        write_reg(3'd0, 16'h002A);
        write_reg(3'd1, 16'h0000);
        tick(2);
        ext_gate_in = 3'b001;
        tick(1);
        check("R4 pin after one edge", {15'd0, gate_out[0]}, 16'h0000);
        tick(1);
        check("R4 pin after two edges", {15'd0, gate_out[0]}, 16'h0001);
        ext_gate_in = '0;
        tick(3);

        // R6: single pulse on channel 1
        write_reg(3'd0, 16'h000C);
        write_reg(3'd3, 16'h0002);
        tick(1);
        ext_gate_in = 3'b010;
        tick(1);
        check("R6 pulse after one edge", {15'd0, gate_out[1]}, 16'h0000);
        tick(1);
        check("R6 pulse opens", {15'd0, gate_out[1]}, 16'h0001);
        tick(3);
        check("R6 pulse held open", {15'd0, gate_out[1]}, 16'h0001);
        ext_gate_in = '0;
        tick(1);
        check("R6 close after one edge", {15'd0, gate_out[1]}, 16'h0001);
        tick(1);
        check("R6 pulse closes", {15'd0, gate_out[1]}, 16'h0000);
        tick(2);
        ext_gate_in = 3'b010;
        tick(4);
        check("R6 second pulse blocked", {15'd0, gate_out[1]}, 16'h0000);
        ext_gate_in = '0;
        tick(3);

        // R7: rewriting 1 does not re-arm
        write_reg(3'd3, 16'h0002);
        tick(1);
        ext_gate_in = 3'b010;
        tick(4);
        check("R7 no re-arm without edge", {15'd0, gate_out[1]}, 16'h0000);
        // R7: arming while the input is high does not open the gate
        write_reg(3'd3, 16'h0000);
        write_reg(3'd3, 16'h0002);
        tick(2);
        check("R7 armed ignores high level", {15'd0, gate_out[1]}, 16'h0000);
        ext_gate_in = '0;
        tick(3);
        ext_gate_in = 3'b010;
        tick(2);
        check("R7 re-armed pulse opens", {15'd0, gate_out[1]}, 16'h0001);
        ext_gate_in = '0;
        tick(3);
        // R5: invert applies to pulse mode
        write_reg(3'd1, 16'h0002);
        check("R5 invert in pulse mode", {15'd0, gate_out[1]}, 16'h0001);

        // R1: global reset re-arms the machine
        rst_n = 1'b0;
        tick(2);
        check("R1 gate during reset", {13'd0, gate_out}, 16'h0000);
        rst_n = 1'b1;
        tick(1);
        check_read("R1 select after reset", 3'd0, 16'h0000);
        write_reg(3'd0, 16'h000C);
        ext_gate_in = 3'b010;
        tick(2);
        check("R1 armed after reset", {15'd0, gate_out[1]}, 16'h0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule